// File: doc/BRIEF.md
# Page Write Buffer and Timed Commit Engine

This unit sits between a serial memory front end and an on-chip byte array of 2^ADDR_W entries. During a write frame it gathers data bytes into a page buffer of PAGE_BYTES slots. The slot pointer starts at the low bits of the frame's start address and steps through the page. When it passes the last slot it wraps to the first one, and a later byte replaces an earlier one. Each slot that received a byte in the frame is marked, and only marked slots are copied into the array.

The front end reports the end of the frame with a one-cycle `csRise` pulse. At that pulse it also reports whether the serial stream stopped exactly on a byte boundary. The protect unit supplies a `permit` level. The commit starts only if the stop was aligned, at least one byte is held and permit is high. The unit then stays `busy` for a fixed number of system clocks and writes the array on the final busy cycle. That cycle is marked by a one-cycle `cycleDone` pulse, which the front end uses to drop its write-enable latch. While busy, the unit ignores every new frame, byte and read request.

A status-register write uses the same timer. Its single payload byte is loaded with `statusLoad` and appears on `statusOut` when the timed cycle ends.

Top module: `page_write_engine`

## Requirements
- R1: After reset, busy, cycleDone, statusOut and rdData are 0, and every array byte reads as 0x00.
- R2: A byte accepted in a frame is stored at {upper start-address bits, slot}. The slot begins at startAddr mod PAGE_BYTES and rises by one per byte, and the upper address bits never change within the frame.
- R3: Once the slot passes PAGE_BYTES-1 it wraps to 0, and the later byte overwrites the earlier one in that slot.
- R4: A commit changes only the slots written in the frame; every other byte of the page keeps its old value.
- R5: A commit starts only on csRise with byteAligned high. A csRise with byteAligned low discards the buffered bytes, busy stays 0 and the array is unchanged.
- R6: A csRise arriving before any data byte in the frame starts no cycle and leaves the array unchanged.
- R7: A csRise with permit low discards the frame: busy stays 0 and neither the array nor statusOut changes.
- R8: An accepted commit raises busy in the cycle after csRise and holds it for exactly CYCLE_CLKS cycles. cycleDone is high in the last busy cycle only, and the array shows the new bytes after that cycle.
- R9: While busy, startValid, byteValid and statusLoad have no effect, and rdData holds its value whatever rdAddr does.
- R10: A status frame (statusLoad carrying the payload on byteData, then an aligned, permitted csRise) runs the same timed cycle, loads statusOut when it completes, and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Opens an array write frame at startAddr |
| startAddr | input | ADDR_W | Start address of the frame |
| byteValid | input | 1 | One complete data byte is on byteData |
| byteData | input | 8 | Data byte, or status payload when statusLoad is high |
| statusLoad | input | 1 | Opens a status write frame with payload byteData |
| csRise | input | 1 | One-cycle pulse: the chip select has gone inactive |
| byteAligned | input | 1 | At csRise: the serial stream ended on a byte boundary |
| permit | input | 1 | At csRise: the protect unit allows the write |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Registered array byte, held while busy |
| statusOut | output | 8 | Committed status byte |
| busy | output | 1 | Timed write cycle in progress |
| cycleDone | output | 1 | One-cycle pulse in the final busy cycle |

## Verification
Assertions watch every cycle for the following: busy rises only after an aligned csRise, a misaligned or unpermitted csRise never starts a cycle, cycleDone falls only inside busy and is followed by idle, rdData stays frozen while busy, and statusOut moves only on a status commit. The page contents after wrap-around, the rule that only written slots are committed, the exact busy length and the absence of effects from traffic injected during busy all depend on data values. Those are shown only by the bench scenarios, which compare whole pages read back through the read port with a reference copy kept in the bench.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic openArr;    // start array frame, load page base and slot
    logic openStat;   // start status frame, latch payload
    logic takeByte;   // store byteData in current slot
    logic discard;    // drop buffered frame
    logic commitArr;  // copy marked slots into the array
    logic commitStat; // copy payload into status register
  } pgwStrobe_t;
endpackage

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int CYCLE_CLKS = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       byteValid,
  input  logic       statusLoad,
  input  logic       csRise,
  input  logic       byteAligned,
  input  logic       permit,
  output pgwStrobe_t strb,
  output logic       busy,
  output logic       cycleDone
);
  localparam int CNT_W = $clog2(CYCLE_CLKS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_BUSY} state_t;

  state_t           state;
  logic             isStat;
  logic             gotData;
  logic [CNT_W-1:0] cnt;
  logic             lastTick;
  logic             okCommit;

  assign lastTick = (cnt == CNT_W'(CYCLE_CLKS - 1));
  assign okCommit = byteAligned && permit && (gotData || (byteValid && !isStat));

  always_comb begin
    strb = '0;
    unique case (state)
      ST_IDLE: begin
        if (startValid)      strb.openArr  = 1'b1;
        else if (statusLoad) strb.openStat = 1'b1;
      end
      ST_FRAME: begin
        if (csRise) begin
          strb.takeByte = byteValid && !isStat;
          strb.discard  = !okCommit;
        end else if (startValid) begin
          strb.openArr = 1'b1;
        end else if (statusLoad) begin
          strb.openStat = 1'b1;
        end else begin
          strb.takeByte = byteValid && !isStat;
        end
      end
      ST_BUSY: begin
        strb.commitArr  = lastTick && !isStat;
        strb.commitStat = lastTick && isStat;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isStat  <= 1'b0;
      gotData <= 1'b0;
      cnt     <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_FRAME: begin
          if (state == ST_FRAME && csRise) begin
            state <= okCommit ? ST_BUSY : ST_IDLE;
            cnt   <= '0;
          end else if (strb.openArr) begin
            state   <= ST_FRAME;
            isStat  <= 1'b0;
            gotData <= 1'b0;
          end else if (strb.openStat) begin
            state   <= ST_FRAME;
            isStat  <= 1'b1;
            gotData <= 1'b1;
          end else if (strb.takeByte) begin
            gotData <= 1'b1;
          end
        end
        ST_BUSY: begin
          if (lastTick) state <= ST_IDLE;
          else          cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state == ST_BUSY);
  assign cycleDone = strb.commitArr || strb.commitStat;

  // R5: a timed cycle is always preceded by an aligned end of frame
  assert_start_after_aligned_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csRise && byteAligned));
  // R5: misaligned end never starts a cycle
  assert_no_misaligned_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && csRise && !byteAligned) |=> !busy);
  // R7: unpermitted end never starts a cycle
  assert_no_unpermitted_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && csRise && !permit) |=> !busy);
  // R8: done pulse lies inside busy and ends it
  assert_done_inside_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> busy);
  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !busy);
endmodule

// File: rtl/pgw_data.sv
module pgw_data
  import pgw_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgwStrobe_t        strb,
  input  logic              busy,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        byteData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic [7:0]        statusOut
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PG_W-1:0]  pageBase;
  logic [OFF_W-1:0] slot;
  logic [7:0]       statBuf;
  logic             slotMask [PAGE_BYTES];
  logic [7:0]       slotData [PAGE_BYTES];
  logic [7:0]       mem      [DEPTH];
  logic             clearAll;

  assign clearAll = strb.openArr || strb.openStat || strb.discard;

  // frame pointer: upper bits fixed, slot wraps inside the page
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageBase <= '0;
      slot     <= '0;
      statBuf  <= '0;
    end else if (strb.openArr) begin
      pageBase <= startAddr[ADDR_W-1:OFF_W];
      slot     <= startAddr[OFF_W-1:0];
    end else if (strb.openStat) begin
      statBuf <= byteData;
    end else if (strb.takeByte) begin
      slot <= slot + 1'b1;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotMask[g] <= 1'b0;
        slotData[g] <= '0;
      end else if (clearAll) begin
        slotMask[g] <= 1'b0;
      end else if (strb.takeByte && slot == OFF_W'(g)) begin
        slotMask[g] <= 1'b1;
        slotData[g] <= byteData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.commitArr) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (slotMask[i]) mem[{pageBase, OFF_W'(i)}] <= slotData[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusOut <= '0;
      rdData    <= '0;
    end else begin
      if (strb.commitStat) statusOut <= statBuf;
      if (!busy)           rdData    <= mem[rdAddr];
    end
  end

  // R9: read port frozen during the timed cycle
  assert_read_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(rdData));
  // R10: status register changes only at a status commit
  assert_status_only_on_commit_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitStat |=> $stable(statusOut));
  // R4: no array commit outside the timed cycle
  assert_commit_inside_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitArr |-> busy);
endmodule

// File: rtl/page_write_engine.sv
module page_write_engine
  import pgw_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              statusLoad,
  input  logic              csRise,
  input  logic              byteAligned,
  input  logic              permit,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic [7:0]        statusOut,
  output logic              busy,
  output logic              cycleDone
);
  pgwStrobe_t strb;

  pgw_ctrl #(.CYCLE_CLKS(CYCLE_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .byteValid(byteValid),
    .statusLoad(statusLoad), .csRise(csRise), .byteAligned(byteAligned),
    .permit(permit), .strb(strb), .busy(busy), .cycleDone(cycleDone)
  );

  pgw_data #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .startAddr(startAddr),
    .byteData(byteData), .rdAddr(rdAddr), .rdData(rdData), .statusOut(statusOut)
  );
endmodule

// File: tb/page_write_engine_tb.sv
module page_write_engine_tb;
  localparam int AW  = 12;
  localparam int PB  = 32;
  localparam int CYC = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN, startValid, byteValid, statusLoad, csRise, byteAligned, permit;
  logic [AW-1:0] startAddr, rdAddr;
  logic [7:0]    byteData, rdData, statusOut;
  logic          busy, cycleDone;

  page_write_engine #(.ADDR_W(AW), .PAGE_BYTES(PB), .CYCLE_CLKS(CYC)) u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .statusLoad(statusLoad),
    .csRise(csRise), .byteAligned(byteAligned), .permit(permit),
    .rdAddr(rdAddr), .rdData(rdData), .statusOut(statusOut),
    .busy(busy), .cycleDone(cycleDone)
  );

  logic [7:0] refMem [1 << AW];
  logic [7:0] refStatus = 8'h00;
  int total = 0;
  int bad   = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] pageOf(input logic [AW-1:0] a);
    return a & ~AW'(PB - 1);
  endfunction

  task automatic readByte(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk) rdAddr = a;
    @(negedge clk) v = rdData;
  endtask

  task automatic checkPage(input logic [AW-1:0] a, input string req);
    logic [AW-1:0] base = pageOf(a);
    for (int i = 0; i < PB; i++) begin
      logic [7:0] v;
      readByte(base + AW'(i), v);
      chk(v == refMem[base + AW'(i)], req, v, refMem[base + AW'(i)]);
    end
  endtask

  // called at the first negedge where busy is expected high
  task automatic watchBusy(input bit inject);
    int cnt = 0, dones = 0, doneAt = -1;
    logic [7:0] hold = rdData;
    bit held = 1;
    while (busy) begin
      if (cycleDone) begin dones++; doneAt = cnt; end
      if (rdData !== hold) held = 0;
      cnt++;
      if (inject) begin
        startValid = 1; startAddr = AW'($urandom);
        byteValid  = 1; byteData  = 8'($urandom);
        statusLoad = (cnt % 3 == 0);
        rdAddr     = AW'($urandom);
      end
      @(negedge clk);
      if (cnt > CYC + 5) break;
    end
    startValid = 0; byteValid = 0; statusLoad = 0;
    chk(cnt == CYC, "R8 busy length", cnt, CYC);
    chk(dones == 1 && doneAt == CYC - 1, "R8 done pulse position", doneAt, CYC - 1);
    chk(cycleDone == 0, "R8 done low after cycle", cycleDone, 0);
    if (inject) chk(held, "R9 rdData held while busy", held, 1);
  endtask

  task automatic arrayFrame(input logic [AW-1:0] a, input int n, input bit aligned,
                            input bit perm, input bit inject, input string req);
    logic [7:0] pbuf [PB];
    bit         pmask [PB];
    int         off;
    bit         expStart;
    for (int i = 0; i < PB; i++) pmask[i] = 0;
    @(negedge clk) begin startValid = 1; startAddr = a; end
    @(negedge clk) startValid = 0;
    off = int'(a) % PB;
    for (int i = 0; i < n; i++) begin
      byteValid = 1; byteData = 8'($urandom);
      pbuf[off] = byteData; pmask[off] = 1; off = (off + 1) % PB;
      @(negedge clk) byteValid = 0;
      if ($urandom % 2 == 1) @(negedge clk);
    end
    csRise = 1; byteAligned = aligned; permit = perm;
    @(negedge clk) begin csRise = 0; byteAligned = 0; end
    expStart = aligned && perm && (n > 0);
    chk(busy == expStart, {req, " busy after cs rise"}, busy, expStart);
    if (expStart) begin
      watchBusy(inject);
      for (int i = 0; i < PB; i++)
        if (pmask[i]) refMem[pageOf(a) + AW'(i)] = pbuf[i];
    end else begin
      repeat (3) @(negedge clk);
      chk(busy == 0, {req, " stays idle"}, busy, 0);
    end
  endtask

  task automatic statusFrame(input logic [7:0] s, input bit perm, input string req);
    @(negedge clk) begin statusLoad = 1; byteData = s; end
    @(negedge clk) begin statusLoad = 0; csRise = 1; byteAligned = 1; permit = perm; end
    @(negedge clk) begin csRise = 0; byteAligned = 0; end
    chk(busy == perm, {req, " busy after status rise"}, busy, perm);
    if (perm) begin
      watchBusy(0);
      refStatus = s;
    end else repeat (3) @(negedge clk);
    chk(statusOut == refStatus, req, statusOut, refStatus);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < (1 << AW); i++) refMem[i] = 8'h00;
    rstN = 0; startValid = 0; byteValid = 0; statusLoad = 0; csRise = 0;
    byteAligned = 0; permit = 1; startAddr = '0; rdAddr = '0; byteData = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(cycleDone == 0, "R1 cycleDone", cycleDone, 0);
    chk(statusOut == 0, "R1 statusOut", statusOut, 0);
    chk(rdData == 0, "R1 rdData", rdData, 0);
    readByte(12'hABC, v);
    chk(v == 0, "R1 array cleared", v, 0);

    arrayFrame(12'h123, 4, 1, 1, 0, "R2");   checkPage(12'h123, "R2 placement");
    arrayFrame(12'h25E, 40, 1, 1, 0, "R3");  checkPage(12'h25E, "R3 wrap overwrite");
    arrayFrame(12'h130, 2, 1, 1, 0, "R4");   checkPage(12'h120, "R4 untouched slots");
    arrayFrame(12'h300, 5, 0, 1, 0, "R5");   checkPage(12'h300, "R5 misaligned discard");
    arrayFrame(12'h400, 0, 1, 1, 0, "R6");   checkPage(12'h400, "R6 no data");
    arrayFrame(12'h500, 3, 1, 0, 0, "R7");   checkPage(12'h500, "R7 not permitted");
    chk(statusOut == refStatus, "R7 status unchanged", statusOut, refStatus);
    arrayFrame(12'h600, 6, 1, 1, 1, "R9");   checkPage(12'h600, "R9 ignored traffic");
    chk(statusOut == refStatus, "R9 status unchanged", statusOut, refStatus);
    checkPage(12'h000, "R9 other page intact");
    statusFrame(8'hA5, 1, "R10 status commit");
    statusFrame(8'h3C, 0, "R7 status blocked");
    checkPage(12'h600, "R10 array unchanged");

    for (int k = 0; k < 10; k++) begin
      logic [AW-1:0] a = AW'($urandom);
      int  n  = int'($urandom % 41);
      bit  al = ($urandom % 8) != 0;
      bit  pm = ($urandom % 8) != 0;
      arrayFrame(a, n, al, pm, 0, "R2 random frame");
      checkPage(a, "R2 random page");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule